// File: doc/BRIEF.md
# Hybrid Branch Direction and Target Predictor

This block gives the fetch stage a guess for every control-transfer instruction it sees: whether the instruction will redirect the flow, where it will go, and which mechanism produced the guess. A small direct-mapped table, filled by resolved outcomes arriving from retirement, supplies a learned direction and target when it holds an entry for the fetch address. When the table has nothing for that address, a fixed rule applies instead. Conditional branches that jump backwards (negative offset) are guessed taken, and those that jump forwards are guessed not taken. Unconditional jumps and calls are always guessed taken.

Returns use a separate mechanism that takes precedence over the table. A circular stack of return addresses gets the address after each accepted call and gives back the newest one for each accepted return. Lookups are combinational on the fetch inputs. The table and the stack change only at the clock edge, so a lookup and an update in the same cycle see the old table contents.

Top module: `brpred_top`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so a conditional branch with a negative offset is predicted taken from the static rule (source code 0), with target PC plus offset.
- R2: On a table hit (valid entry at index PC[7:2] whose stored tag matches the remaining PC bits), the source is 1. The direction is the upper bit of the entry's 2-bit counter. The target is the stored target when taken and PC+4 when not taken.
- R3: On a table miss for a conditional branch (kind 0), a negative offset (bit 31 set) predicts taken with target PC plus offset. An offset of zero or more predicts not taken with target PC+4. Source is 0.
- R4: On a table miss for a jump (kind 1) or a call (kind 2), the prediction is taken, the target is PC plus offset, and the source is 0.
- R5: An update that misses the table fills the entry with the tag, the resolved target and a counter of 2 if taken or 1 if not taken.
- R6: An update that hits moves the counter one step toward the outcome, saturating at 0 and 3, and replaces the stored target only when the outcome is taken.
- R7: A lookup in the same cycle as an update to the same entry sees the contents from before the update. The new contents are visible from the next cycle.
- R8: A return (kind 3) is predicted taken with source 2, and its target is the newest stack entry, whatever the table holds for that address.
- R9: An accepted call (fetch_valid high) pushes PC+4. Once 16 entries are held, a further push overwrites the oldest entry and the depth stays 16.
- R10: A return accepted on an empty stack predicts the most recently popped address (zero after reset) and leaves the stack unchanged.
- R11: Two addresses with the same index but different tags map to one entry: the one not held misses. An update for it replaces the entry.
- R12: While fetch_valid is low, calls and returns do not change the stack, but the outputs are still computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch is accepted; allows stack push or pop |
| fetch_pc | input | 32 | Address of the fetched instruction |
| fetch_kind | input | 2 | 0 conditional, 1 jump, 2 call, 3 return |
| fetch_disp | input | 32 | Two's-complement branch offset |
| upd_valid | input | 1 | Resolved outcome from retirement is present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next address |
| pred_src | output | 2 | 0 static rule, 1 table, 2 return stack |

## Verification
Some properties are checked on every cycle. Returns always come from the stack as taken predictions, and a not-taken guess always targets PC+4. On a miss, static conditional guesses follow the sign bit of the offset. The stack depth never exceeds 16; it rises on a push below capacity, holds when nothing valid pops or pushes, and stays at zero on an underflow. Other behaviours need the bench's scenarios. These are the counter sequences, which entry is filled, the read-before-write ordering, eviction by aliasing, and the order in which return addresses come back after overflow.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_CALL = 2'd2,
    KIND_RET  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_STATIC = 2'd0,
    SRC_TABLE  = 2'd1,
    SRC_STACK  = 2'd2
  } pred_src_e;

  // Saturating two-bit confidence step toward the resolved direction.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == 2'd3) ? c : c + 2'd1;
    else       r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/brpred_btb.sv
module brpred_btb #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [1:0]      lk_ctr,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  import brpred_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             up_hit, tgt_wr;
  logic [1:0]       ctr_n;

  // Tag keeps every PC bit that is not part of the index.
  assign lk_idx = lk_pc[IDX_W+1:2];
  assign lk_tag = {lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0]};
  assign up_idx = up_pc[IDX_W+1:2];
  assign up_tag = {up_pc[PC_W-1:IDX_W+2], up_pc[1:0]};

  // Lookup reads current register contents (read-before-write).
  always_comb begin
    lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    lk_ctr    = ctr_q[lk_idx];
    lk_target = tgt_q[lk_idx];
  end

  // Next-state for the update port.
  always_comb begin
    up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
    if (up_hit) begin
      ctr_n  = ctr_step(ctr_q[up_idx], up_taken);
      tgt_wr = up_taken;
    end else begin
      ctr_n  = up_taken ? 2'd2 : 2'd1;
      tgt_wr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (up_valid) begin
      valid_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      tag_q[up_idx] <= up_tag;
      ctr_q[up_idx] <= ctr_n;
    end
    if (up_valid && tgt_wr) begin
      tgt_q[up_idx] <= up_target;
    end
  end

endmodule

// File: rtl/brpred_ras.sv
module brpred_ras #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               push_val,
  output logic [W-1:0]               top_val,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     stack_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     last_q, last_n;
  logic             wr_en, state_en, empty;

  assign ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_dec  = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
  assign empty    = (cnt_q == '0);
  assign state_en = push | pop;

  assign top_val = empty ? last_q : stack_q[ptr_q];
  assign depth   = cnt_q;

  always_comb begin
    ptr_n  = ptr_q;
    cnt_n  = cnt_q;
    last_n = last_q;
    wr_en  = 1'b0;
    if (push) begin
      ptr_n = ptr_inc;
      wr_en = 1'b1;
      if (cnt_q != FULL) cnt_n = cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      ptr_n  = ptr_dec;
      cnt_n  = cnt_q - CNT_W'(1);
      last_n = stack_q[ptr_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= LAST;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (state_en) begin
      ptr_q  <= ptr_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stack_q[ptr_inc] <= push_val;
  end

endmodule

// File: rtl/brpred_select.sv
module brpred_select #(
  parameter int PC_W = 32
) (
  input  logic [1:0]      kind,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] disp,
  input  logic            tbl_hit,
  input  logic [1:0]      tbl_ctr,
  input  logic [PC_W-1:0] tbl_target,
  input  logic [PC_W-1:0] stack_top,
  output logic            taken,
  output logic [PC_W-1:0] target,
  output logic [1:0]      src
);
  import brpred_pkg::*;

  logic [PC_W-1:0] seq_pc, jump_pc;
  br_kind_e        k;

  assign seq_pc  = pc + PC_W'(4);
  assign jump_pc = pc + disp;
  assign k       = br_kind_e'(kind);

  always_comb begin
    taken  = 1'b0;
    target = seq_pc;
    src    = SRC_STATIC;
    if (k == KIND_RET) begin
      taken  = 1'b1;
      target = stack_top;
      src    = SRC_STACK;
    end else if (tbl_hit) begin
      taken  = tbl_ctr[1];
      target = tbl_ctr[1] ? tbl_target : seq_pc;
      src    = SRC_TABLE;
    end else begin
      taken  = (k == KIND_COND) ? disp[PC_W-1] : 1'b1;
      target = taken ? jump_pc : seq_pc;
      src    = SRC_STATIC;
    end
  end

endmodule

// File: rtl/brpred_top.sv
module brpred_top #(
  parameter int PC_W        = 32,
  parameter int BTB_ENTRIES = 64,
  parameter int RAS_DEPTH   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [1:0]      fetch_kind,
  input  logic [PC_W-1:0] fetch_disp,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic [1:0]      pred_src
);
  import brpred_pkg::*;

  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  logic            tbl_hit;
  logic [1:0]      tbl_ctr;
  logic [PC_W-1:0] tbl_target;
  logic [PC_W-1:0] stack_top;
  logic [CNT_W-1:0] ras_depth;
  logic            do_push, do_pop;

  assign do_push = fetch_valid && (fetch_kind == KIND_CALL);
  assign do_pop  = fetch_valid && (fetch_kind == KIND_RET);

  brpred_btb #(.ENTRIES(BTB_ENTRIES), .PC_W(PC_W)) u_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (fetch_pc),
    .lk_hit    (tbl_hit),
    .lk_ctr    (tbl_ctr),
    .lk_target (tbl_target),
    .up_valid  (upd_valid),
    .up_pc     (upd_pc),
    .up_taken  (upd_taken),
    .up_target (upd_target)
  );

  brpred_ras #(.DEPTH(RAS_DEPTH), .W(PC_W)) u_ras (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_push),
    .pop      (do_pop),
    .push_val (fetch_pc + PC_W'(4)),
    .top_val  (stack_top),
    .depth    (ras_depth)
  );

  brpred_select #(.PC_W(PC_W)) u_sel (
    .kind       (fetch_kind),
    .pc         (fetch_pc),
    .disp       (fetch_disp),
    .tbl_hit    (tbl_hit),
    .tbl_ctr    (tbl_ctr),
    .tbl_target (tbl_target),
    .stack_top  (stack_top),
    .taken      (pred_taken),
    .target     (pred_target),
    .src        (pred_src)
  );

endmodule

// File: rtl/brpred_chk.sv
module brpred_chk #(
  parameter int PC_W      = 32,
  parameter int RAS_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           fetch_valid,
  input logic [PC_W-1:0]                fetch_pc,
  input logic [1:0]                     fetch_kind,
  input logic [PC_W-1:0]                fetch_disp,
  input logic                           pred_taken,
  input logic [PC_W-1:0]                pred_target,
  input logic [1:0]                     pred_src,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_depth
);
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RAS_DEPTH);

  assert_ret_from_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == 2'd3) |-> (pred_src == 2'd2 && pred_taken));

  assert_not_taken_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_taken) |-> (pred_target == fetch_pc + PC_W'(4)));

  assert_static_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_src == 2'd0 && fetch_kind == 2'd0) |-> (pred_taken == fetch_disp[PC_W-1]));

  assert_static_uncond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_src == 2'd0 && fetch_kind != 2'd0) |-> pred_taken);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ras_depth <= FULL);

  assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_kind == 2'd2 && ras_depth != FULL) |=> (ras_depth == $past(ras_depth) + 1'b1));

  assert_underflow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_kind == 2'd3 && ras_depth == '0) |=> (ras_depth == '0));

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid || fetch_kind[1] == 1'b0) |=> $stable(ras_depth));

endmodule

bind brpred_top brpred_chk #(.PC_W(PC_W), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .fetch_kind  (fetch_kind),
  .fetch_disp  (fetch_disp),
  .pred_taken  (pred_taken),
  .pred_target (pred_target),
  .pred_src    (pred_src),
  .ras_depth   (ras_depth)
);

// File: tb/brpred_top_tb.sv
module brpred_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        fetch_valid, upd_valid, upd_taken;
  logic [31:0] fetch_pc, fetch_disp, upd_pc, upd_target;
  logic [1:0]  fetch_kind;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic [1:0]  pred_src;

  int checks = 0;
  int errors = 0;

  brpred_top u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_kind(fetch_kind), .fetch_disp(fetch_disp), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_taken(pred_taken), .pred_target(pred_target), .pred_src(pred_src)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_pred(input string req, input logic et, input logic [31:0] etg,
                             input logic [1:0] es);
    checks++;
    if ({pred_taken, pred_target, pred_src} !== {et, etg, es}) begin
      errors++;
      $display("FAIL %s: got taken=%0b target=%h src=%0d, expected taken=%0b target=%h src=%0d",
               req, pred_taken, pred_target, pred_src, et, etg, es);
    end
  endtask

  task automatic fetch(input logic v, input logic [1:0] k, input logic [31:0] pc,
                       input logic [31:0] d);
    @(negedge clk);
    fetch_valid = v; fetch_kind = k; fetch_pc = pc; fetch_disp = d;
    upd_valid = 1'b0;
    #1;
  endtask

  task automatic update(input logic [31:0] pc, input logic t, input logic [31:0] tg);
    @(negedge clk);
    fetch_valid = 1'b0; fetch_kind = 2'd0;
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tg;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_kind = 2'd0; fetch_pc = '0; fetch_disp = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every index misses after reset; backward conditional is taken
    for (int i = 0; i < 64; i++) begin
      fetch(1'b1, 2'd0, 32'h1000 + i * 4, -32'sd8);
      expect_pred("R1", 1'b1, 32'h1000 + i * 4 - 8, 2'd0);
    end

    // R10: return on empty stack after reset predicts zero
    fetch(1'b1, 2'd3, 32'h500, 32'd0);
    expect_pred("R10", 1'b1, 32'h0, 2'd2);

    // R3/R4: offset sweep on misses; calls observed with fetch_valid low (R12)
    for (int i = 0; i <= 40; i++) begin
      logic [31:0] d, pc;
      d  = 32'((i - 20) * 4);
      pc = 32'h3000;
      fetch(1'b1, 2'd0, pc, d);
      if (d[31]) expect_pred("R3", 1'b1, pc + d, 2'd0);
      else       expect_pred("R3", 1'b0, pc + 4, 2'd0);
      fetch(1'b1, 2'd1, pc, d);
      expect_pred("R4", 1'b1, pc + d, 2'd0);
      fetch(1'b0, 2'd2, pc, d);
      expect_pred("R4", 1'b1, pc + d, 2'd0);
    end

    // R5: fill all 64 entries, odd ones taken
    for (int i = 0; i < 64; i++) update(32'h4000 + i * 4, i[0], 32'h8000 + i * 16);
    for (int i = 0; i < 64; i++) begin
      fetch(1'b1, 2'd0, 32'h4000 + i * 4, 32'd64);
      if (i[0]) expect_pred("R5", 1'b1, 32'h8000 + i * 16, 2'd1);
      else      expect_pred("R5", 1'b0, 32'h4000 + i * 4 + 4, 2'd1);
    end

    // R2/R6: counter walk on entry 0 (starts at 1), saturating both ends
    begin
      logic [1:0]  c;
      logic [31:0] tg;
      logic [7:0]  pat;
      c = 2'd1; tg = 32'h8000;
      pat = 8'b1000_0111; // applied LSB first: T T T N N N N T
      for (int s = 0; s < 8; s++) begin
        logic t;
        t = pat[s];
        update(32'h4000, t, 32'h9000 + s * 4);
        if (t) begin
          c  = (c == 2'd3) ? 2'd3 : c + 2'd1;
          tg = 32'h9000 + s * 4;
        end else begin
          c  = (c == 2'd0) ? 2'd0 : c - 2'd1;
        end
        fetch(1'b1, 2'd0, 32'h4000, -32'sd4);
        if (c[1]) expect_pred("R6", 1'b1, tg, 2'd1);
        else      expect_pred("R2", 1'b0, 32'h4004, 2'd1);
      end
    end

    // R7/R11: aliasing address on index 5, lookup in the update cycle
    @(negedge clk);
    fetch_valid = 1'b1; fetch_kind = 2'd0; fetch_pc = 32'h1_0014; fetch_disp = 32'd16;
    upd_valid = 1'b1; upd_pc = 32'h1_0014; upd_taken = 1'b1; upd_target = 32'hA000;
    #1;
    expect_pred("R7", 1'b0, 32'h1_0018, 2'd0);
    fetch(1'b1, 2'd0, 32'h1_0014, 32'd16);
    expect_pred("R7", 1'b1, 32'hA000, 2'd1);
    fetch(1'b1, 2'd0, 32'h4014, 32'd8);
    expect_pred("R11", 1'b0, 32'h4018, 2'd0);

    // R8: return overrides a table hit at the same address
    fetch(1'b1, 2'd3, 32'h1_0014, 32'd0);
    expect_pred("R8", 1'b1, 32'h0, 2'd2);

    // R12: invalid returns do not pop; R8/R10 pop order and underflow
    fetch(1'b1, 2'd2, 32'h2000, 32'd100);
    fetch(1'b1, 2'd2, 32'h2100, 32'd100);
    fetch(1'b0, 2'd3, 32'h600, 32'd0);
    expect_pred("R12", 1'b1, 32'h2104, 2'd2);
    fetch(1'b0, 2'd2, 32'h2200, 32'd0);
    fetch(1'b0, 2'd3, 32'h600, 32'd0);
    expect_pred("R12", 1'b1, 32'h2104, 2'd2);
    fetch(1'b1, 2'd3, 32'h600, 32'd0);
    expect_pred("R8", 1'b1, 32'h2104, 2'd2);
    fetch(1'b1, 2'd3, 32'h600, 32'd0);
    expect_pred("R8", 1'b1, 32'h2004, 2'd2);
    fetch(1'b1, 2'd3, 32'h600, 32'd0);
    expect_pred("R10", 1'b1, 32'h2004, 2'd2);

    // R9: 20 pushes keep only the newest 16; R10 after draining
    for (int k = 0; k < 20; k++) fetch(1'b1, 2'd2, 32'h5000 + k * 8, 32'd40);
    for (int k = 19; k >= 4; k--) begin
      fetch(1'b1, 2'd3, 32'h700, 32'd0);
      expect_pred("R9", 1'b1, 32'h5000 + k * 8 + 4, 2'd2);
    end
    fetch(1'b1, 2'd3, 32'h700, 32'd0);
    expect_pred("R10", 1'b1, 32'h5000 + 4 * 8 + 4, 2'd2);
    fetch(1'b1, 2'd3, 32'h700, 32'd0);
    expect_pred("R10", 1'b1, 32'h5000 + 4 * 8 + 4, 2'd2);

    @(negedge clk);
    fetch_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule